// File: doc/BRIEF.md
# Multi-port GPIO register bank

This block is an APB slave that holds the software-visible state of up to four general-purpose I/O ports of up to 32 lines each. Every present port owns an output-value register and a direction register, both read/write, and a read-only view of its input pins taken through a two-stage synchronizer. The stored values drive the pin outputs and the per-line output enables.

The interrupt registers of the bank belong to a companion interrupt unit. This block decodes their offsets and hands the companion a one-hot select together with a write flag. It returns the companion's read data on reads of those offsets. A parameter picks one of two offset layouts for those registers. Bus phases are tracked by a small state machine. `BUS_IDLE` moves to `BUS_ARMED` on a setup cycle (select high, enable low). `BUS_ARMED` returns to `BUS_IDLE` either on the completing enable cycle, where the transfer is committed, or when the select drops. A setup cycle that repeats while armed keeps the machine in `BUS_ARMED`.

Top module: `gpio_bank`

## Requirements
- R1: After reset every output-value and direction register is zero, so `gpio_oe` and `gpio_out` are all zero and every register reads as zero.
- R2: The output-value register of port p is at byte offset 12·p (0x00, 0x0c, 0x18, 0x24). It is readable and writable, and its bits appear on `gpio_out[p*LINES +: LINES]` from the cycle after the write commits.
- R3: The direction register of port p is at byte offset 12·p+4 (0x04, 0x10, 0x1c, 0x28). It is readable and writable and drives `gpio_oe[p*LINES +: LINES]`, where 1 means the line is an output and 0 means it is an input.
- R4: The pin-value register of port p is at byte offset 0x50+4·p. It returns `gpio_in` after a two-flop synchronizer, so a pin held for three clock edges before the enable cycle is read correctly. Writes to it are ignored.
- R5: Bits at or above `LINES` read as zero. Offsets belonging to port indices at or above `N_PORTS` read as zero and ignore writes.
- R6: With `LAYOUT`=0 the companion select bits map to these byte offsets: bit0 enable at 0x30, bit1 mask at 0x34, bit2 type at 0x38, bit3 polarity at 0x3c, bit4 status at 0x40, bit5 debounce at 0x48, bit6 end-of-interrupt at 0x4c.
- R7: With `LAYOUT`=1 enable stays at 0x30 and debounce stays at 0x48. Mask moves to 0x44, type to 0x34, polarity to 0x38, status to 0x3c and end-of-interrupt to 0x40. All port offsets are the same as in layout 0.
- R8: `irq_sel` is nonzero only during a committing enable cycle, and then it is one-hot. `irq_write` is high only in such a cycle when it is a write. A read of an interrupt offset returns `irq_rdata`.
- R9: Offsets that are not mapped, including those with a nonzero address bit [1:0], read as zero and their writes change nothing. `pready` is always 1 and `pslverr` is always 0.
- R10: An enable cycle that is not preceded by a setup cycle is ignored: nothing is written and nothing is selected.
- R11: `gpio_out` and `gpio_oe` change only on the clock edge that ends a committing write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Enable phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | AW | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the committing read cycle, otherwise zero |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| gpio_in | input | N_PORTS*LINES | Asynchronous pin inputs, port 0 in the low bits |
| gpio_out | output | N_PORTS*LINES | Pin output values |
| gpio_oe | output | N_PORTS*LINES | Pin output enables |
| irq_sel | output | 7 | One-hot select of the interrupt register being accessed |
| irq_write | output | 1 | The selected interrupt register is being written |
| irq_rdata | input | 32 | Read data from the companion interrupt unit |

## Verification
A write to a direction register and a change on the input pins can land in the same clock cycle. The synchronizer and the register file must not interfere with each other. The bench starts a direction write on the same edge where it changes the port's pins. It then checks that the direction read-back and `gpio_oe` carry the written value, and that a later pin-value read returns the new pins whatever the direction is. A full sweep of all 64 word offsets on two configurations (three 12-line ports with layout 0, and four 32-line ports with layout 1) judges the decoding, the masking and the companion selects arithmetically.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int DATA_W        = 32;
    localparam int IRQ_N         = 7;   // companion register selects
    localparam int PORT_STRIDE_W = 3;   // words between port register pairs
    localparam int EXT_BASE_W    = 20;  // word index of first pin-value register

    typedef enum logic {
        BUS_IDLE,
        BUS_ARMED
    } bus_state_e;

    // word index of companion register k under a given layout
    // k: 0 enable, 1 mask, 2 type, 3 polarity, 4 status, 5 debounce, 6 eoi
    function automatic int irq_word(input int layout, input int k);
        int w;
        w = 0;
        if (layout == 0) begin
            case (k)
                0: w = 12;
                1: w = 13;
                2: w = 14;
                3: w = 15;
                4: w = 16;
                5: w = 18;
                default: w = 19;
            endcase
        end else begin
            case (k)
                0: w = 12;
                1: w = 17;
                2: w = 13;
                3: w = 14;
                4: w = 15;
                5: w = 18;
                default: w = 16;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_bank_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int LAYOUT  = 0,
    parameter int WW      = 6
) (
    input  logic [WW-1:0]      widx,
    input  logic               aligned,
    output logic [N_PORTS-1:0] dat_hit,
    output logic [N_PORTS-1:0] dir_hit,
    output logic [N_PORTS-1:0] ext_hit,
    output logic [IRQ_N-1:0]   irq_hit
);

    generate
        for (genvar p = 0; p < N_PORTS; p++) begin : g_port
            localparam int DAT_W = PORT_STRIDE_W * p;
            localparam int DIR_W = PORT_STRIDE_W * p + 1;
            localparam int EXT_W = EXT_BASE_W + p;
            assign dat_hit[p] = aligned && (widx == WW'(DAT_W));
            assign dir_hit[p] = aligned && (widx == WW'(DIR_W));
            assign ext_hit[p] = aligned && (widx == WW'(EXT_W));
        end
        for (genvar k = 0; k < IRQ_N; k++) begin : g_irq
            localparam int KW = irq_word(LAYOUT, k);
            assign irq_hit[k] = aligned && (widx == WW'(KW));
        end
    endgenerate

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dat,
    input  logic             wr_dir,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] dat_q,
    output logic [LINES-1:0] dir_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q <= '0;
            dir_q <= '0;
        end else begin
            if (wr_dat) dat_q <= wdata;
            if (wr_dir) dir_q <= wdata;
        end
    end

endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;
    logic [1:0]   age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    // edges seen since reset, saturating; lets the lag check start safely
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age <= '0;
        else if (age != 2'd3)  age <= age + 2'd1;
    end

    AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (q == $past(d, 2))); // R4

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int LINES   = 32,
    parameter int LAYOUT  = 0,
    parameter int AW      = 8
) (
    input  logic                       pclk,
    input  logic                       presetn,
    input  logic                       psel,
    input  logic                       penable,
    input  logic                       pwrite,
    input  logic [AW-1:0]              paddr,
    input  logic [DATA_W-1:0]          pwdata,
    output logic [DATA_W-1:0]          prdata,
    output logic                       pready,
    output logic                       pslverr,
    input  logic [N_PORTS*LINES-1:0]   gpio_in,
    output logic [N_PORTS*LINES-1:0]   gpio_out,
    output logic [N_PORTS*LINES-1:0]   gpio_oe,
    output logic [IRQ_N-1:0]           irq_sel,
    output logic                       irq_write,
    input  logic [DATA_W-1:0]          irq_rdata
);

    localparam int WW = AW - 2;

    bus_state_e state_q, state_d;
    logic              fire;
    logic              wr_en;
    logic [DATA_W-1:0] rd_mux;

    logic [N_PORTS-1:0] dat_hit, dir_hit, ext_hit;
    logic [IRQ_N-1:0]   irq_hit;

    logic [LINES-1:0] dat_q [N_PORTS];
    logic [LINES-1:0] dir_q [N_PORTS];
    logic [LINES-1:0] ext_q [N_PORTS];

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    // ---------------- bus phase state machine ----------------
    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) state_q <= BUS_IDLE;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:  if (psel && !penable) state_d = BUS_ARMED;
            BUS_ARMED: if (!psel || penable) state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        fire      = (state_q == BUS_ARMED) && psel && penable;
        wr_en     = fire && pwrite;
        prdata    = (fire && !pwrite) ? rd_mux : '0;
        irq_sel   = fire ? irq_hit : '0;
        irq_write = wr_en && (|irq_hit);
    end

    // ---------------- decode ----------------
    gpio_addr_dec #(
        .N_PORTS (N_PORTS),
        .LAYOUT  (LAYOUT),
        .WW      (WW)
    ) u_dec (
        .widx    (paddr[AW-1:2]),
        .aligned (paddr[1:0] == 2'b00),
        .dat_hit (dat_hit),
        .dir_hit (dir_hit),
        .ext_hit (ext_hit),
        .irq_hit (irq_hit)
    );

    // ---------------- per-port storage and pins ----------------
    generate
        for (genvar p = 0; p < N_PORTS; p++) begin : g_port
            gpio_port_regs #(.LINES(LINES)) u_regs (
                .clk    (pclk),
                .rst_n  (presetn),
                .wr_dat (wr_en && dat_hit[p]),
                .wr_dir (wr_en && dir_hit[p]),
                .wdata  (pwdata[LINES-1:0]),
                .dat_q  (dat_q[p]),
                .dir_q  (dir_q[p])
            );
            gpio_sync2 #(.W(LINES)) u_sync (
                .clk   (pclk),
                .rst_n (presetn),
                .d     (gpio_in[p*LINES +: LINES]),
                .q     (ext_q[p])
            );
            assign gpio_out[p*LINES +: LINES] = dat_q[p];
            assign gpio_oe [p*LINES +: LINES] = dir_q[p];
        end
    endgenerate

    // ---------------- read mux ----------------
    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            if (dat_hit[p]) rd_mux = DATA_W'(dat_q[p]);
            if (dir_hit[p]) rd_mux = DATA_W'(dir_q[p]);
            if (ext_hit[p]) rd_mux = DATA_W'(ext_q[p]);
        end
        if (|irq_hit) rd_mux = irq_rdata;
    end

    // ---------------- assertions ----------------
    AST_SEL_ONEHOT: assert property (@(posedge pclk) disable iff (!presetn)
        $onehot0(irq_sel)); // R8

    AST_SEL_IN_ENABLE: assert property (@(posedge pclk) disable iff (!presetn)
        (|irq_sel) |-> (psel && penable)); // R8

    AST_OUT_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
        !(psel && penable && pwrite) |=> $stable(gpio_out)); // R11

    AST_OE_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
        !(psel && penable && pwrite) |=> $stable(gpio_oe)); // R11

    AST_ORPHAN_ENABLE: assert property (@(posedge pclk) disable iff (!presetn)
        (state_q == BUS_IDLE && psel && penable)
        |=> ($stable(gpio_out) && $stable(gpio_oe))); // R10

    AST_IDLE_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
        !psel |-> (prdata == '0 && irq_write == 1'b0)); // R8

endmodule

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;

    logic pclk = 1'b0;
    logic presetn = 1'b0;
    always #4 pclk = ~pclk;   // 125 MHz

    logic        psel = 0, penable = 0, pwrite = 0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] irq_rdata = '0;
    logic [31:0] pin_w [4];

    // uut: three 12-line ports, layout 0; uut_alt: four 32-line ports, layout 1
    logic [31:0]  prdata0, prdata1;
    logic         pready0, pready1, pslverr0, pslverr1;
    logic [35:0]  gin0, gout0, goe0;
    logic [127:0] gin1, gout1, goe1;
    logic [6:0]   sel0, sel1;
    logic         iw0, iw1;

    assign gin0 = {pin_w[2][11:0], pin_w[1][11:0], pin_w[0][11:0]};
    assign gin1 = {pin_w[3], pin_w[2], pin_w[1], pin_w[0]};

    gpio_bank #(.N_PORTS(3), .LINES(12), .LAYOUT(0), .AW(8)) uut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata0),
        .pready(pready0), .pslverr(pslverr0), .gpio_in(gin0), .gpio_out(gout0),
        .gpio_oe(goe0), .irq_sel(sel0), .irq_write(iw0), .irq_rdata(irq_rdata));

    gpio_bank #(.N_PORTS(4), .LINES(32), .LAYOUT(1), .AW(8)) uut_alt (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata1),
        .pready(pready1), .pslverr(pslverr1), .gpio_in(gin1), .gpio_out(gout1),
        .gpio_oe(goe1), .irq_sel(sel1), .irq_write(iw1), .irq_rdata(irq_rdata));

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] m_dat [4];
    logic [31:0] m_dir [4];

    logic [31:0] c_rd0, c_rd1;
    logic [6:0]  c_sel0, c_sel1;
    logic        c_iw0, c_iw1, c_ok;

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // companion index per requirement R6 / R7, -1 if none
    function automatic int irq_idx(input int layout, input int w);
        int k;
        k = -1;
        if (layout == 0) begin
            case (w)
                12: k = 0; 13: k = 1; 14: k = 2; 15: k = 3;
                16: k = 4; 18: k = 5; 19: k = 6; default: k = -1;
            endcase
        end else begin
            case (w)
                12: k = 0; 17: k = 1; 13: k = 2; 14: k = 3;
                15: k = 4; 18: k = 5; 16: k = 6; default: k = -1;
            endcase
        end
        return k;
    endfunction

    function automatic logic [31:0] exp_read(input int cfg, input int w);
        int np;
        logic [31:0] mask;
        np   = (cfg == 0) ? 3 : 4;
        mask = (cfg == 0) ? 32'h0000_0FFF : 32'hFFFF_FFFF;
        if (irq_idx(cfg, w) >= 0) return 32'hC0DE_0000 | 32'(w * 4);
        if (w < 3 * np && (w % 3) == 0) return m_dat[w / 3] & mask;
        if (w < 3 * np && (w % 3) == 1) return m_dir[w / 3] & mask;
        if (w >= 20 && w < 20 + np) return pin_w[w - 20] & mask;
        return 32'h0;
    endfunction

    function automatic logic [6:0] exp_sel(input int cfg, input int w);
        int k;
        k = irq_idx(cfg, w);
        return (k < 0) ? 7'h0 : 7'(1 << k);
    endfunction

    task automatic apb_xfer(input bit wr, input logic [7:0] a, input logic [31:0] wd);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = wd;
        irq_rdata = 32'hC0DE_0000 | 32'(a);
        @(negedge pclk);
        penable = 1;
        #1;
        c_rd0 = prdata0; c_rd1 = prdata1;
        c_sel0 = sel0;   c_sel1 = sel1;
        c_iw0 = iw0;     c_iw1 = iw1;
        c_ok = pready0 && pready1 && !pslverr0 && !pslverr1;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] wd);
        int w;
        apb_xfer(1'b1, a, wd);
        w = int'(a) / 4;
        if (a[1:0] == 2'b00 && w < 12 && (w % 3) == 0) m_dat[w / 3] = wd;
        if (a[1:0] == 2'b00 && w < 12 && (w % 3) == 1) m_dir[w / 3] = wd;
    endtask

    task automatic check_pins(input string req);
        for (int p = 0; p < 3; p++) begin
            chk(gout0[p*12 +: 12] == m_dat[p][11:0], {req, " R2 out"},
                128'(gout0[p*12 +: 12]), 128'(m_dat[p][11:0]));
            chk(goe0[p*12 +: 12] == m_dir[p][11:0], {req, " R3 oe"},
                128'(goe0[p*12 +: 12]), 128'(m_dir[p][11:0]));
        end
        for (int p = 0; p < 4; p++) begin
            chk(gout1[p*32 +: 32] == m_dat[p], {req, " R2 out alt"},
                128'(gout1[p*32 +: 32]), 128'(m_dat[p]));
            chk(goe1[p*32 +: 32] == m_dir[p], {req, " R3 oe alt"},
                128'(goe1[p*32 +: 32]), 128'(m_dir[p]));
        end
    endtask

    task automatic sweep(input string req);
        for (int w = 0; w < 64; w++) begin
            apb_xfer(1'b0, 8'(w * 4), 32'h0);
            chk(c_rd0 == exp_read(0, w), {req, " R4 R5 R9 read"}, 128'(c_rd0),
                128'(exp_read(0, w)));
            chk(c_rd1 == exp_read(1, w), {req, " R4 R5 R9 read alt"}, 128'(c_rd1),
                128'(exp_read(1, w)));
            chk(c_sel0 == exp_sel(0, w), {req, " R6 sel"}, 128'(c_sel0),
                128'(exp_sel(0, w)));
            chk(c_sel1 == exp_sel(1, w), {req, " R7 sel"}, 128'(c_sel1),
                128'(exp_sel(1, w)));
            chk(!c_iw0 && !c_iw1, {req, " R8 no write flag on read"},
                128'({c_iw0, c_iw1}), 128'(0));
            chk(c_ok, {req, " R9 ready/err"}, 128'(c_ok), 128'(1));
        end
    endtask

    initial begin : watchdog
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        for (int p = 0; p < 4; p++) begin
            m_dat[p] = '0; m_dir[p] = '0; pin_w[p] = '0;
        end
        repeat (3) @(negedge pclk);
        // R1: reset state
        chk(gout0 == '0 && goe0 == '0, "R1 pins after reset",
            128'({gout0, goe0}), 128'(0));
        chk(gout1 == '0 && goe1 == '0, "R1 pins after reset alt",
            128'(gout1 | goe1), 128'(0));
        presetn = 1'b1;
        repeat (2) @(negedge pclk);
        chk(sel0 == '0 && sel1 == '0, "R8 idle select", 128'({sel0, sel1}), 128'(0));
        sweep("R1 reset sweep");

        // R2 R3: write every port pair
        for (int p = 0; p < 4; p++) begin
            do_write(8'(12 * p),     32'hA5C3_0F96 ^ (32'(p) * 32'h1111_1111));
            do_write(8'(12 * p + 4), 32'h5A3C_F069 ^ (32'(p) * 32'h0101_0101));
        end
        check_pins("R2 R3 write");

        // R4 R5: pin patterns
        for (int p = 0; p < 4; p++) pin_w[p] = 32'h1357_9BDF ^ (32'(p) * 32'h0F0F_0F0F);
        repeat (3) @(negedge pclk);
        sweep("R2 R3 R4 pattern sweep");

        // R4: pin-value writes ignored
        do_write(8'h50, 32'hFFFF_FFFF);
        do_write(8'h5C, 32'h0000_0000);
        apb_xfer(1'b0, 8'h50, 0);
        chk(c_rd0 == (pin_w[0] & 32'hFFF), "R4 ext write ignored", 128'(c_rd0),
            128'(pin_w[0] & 32'hFFF));
        chk(c_rd1 == pin_w[0], "R4 ext write ignored alt", 128'(c_rd1), 128'(pin_w[0]));
        check_pins("R4 ext write");

        // R9: unmapped and misaligned writes
        do_write(8'h08, 32'hFFFF_FFFF);
        do_write(8'h70, 32'hFFFF_FFFF);
        do_write(8'h01, 32'hFFFF_FFFF);
        do_write(8'h05, 32'h0000_0000);
        check_pins("R9 unmapped writes");
        apb_xfer(1'b0, 8'h01, 0);
        chk(c_rd0 == 0 && c_rd1 == 0, "R9 misaligned read", 128'({c_rd0, c_rd1}), 128'(0));

        // R10: enable without setup
        @(negedge pclk);
        psel = 1; penable = 1; pwrite = 1; paddr = 8'h00; pwdata = 32'hDEAD_BEEF;
        paddr = 8'h30;
        #1;
        chk(sel0 == 0 && sel1 == 0 && !iw0, "R10 orphan select", 128'({sel0, sel1}), 128'(0));
        paddr = 8'h00;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
        @(negedge pclk);
        check_pins("R10 orphan enable");

        // R8: companion write flags
        for (int w = 12; w < 20; w++) begin
            apb_xfer(1'b1, 8'(w * 4), 32'h1234_5678);
            chk(c_iw0 == (irq_idx(0, w) >= 0), "R8 write flag", 128'(c_iw0),
                128'(irq_idx(0, w) >= 0));
            chk(c_iw1 == (irq_idx(1, w) >= 0), "R8 write flag alt", 128'(c_iw1),
                128'(irq_idx(1, w) >= 0));
            chk(c_sel0 == exp_sel(0, w), "R6 write select", 128'(c_sel0), 128'(exp_sel(0, w)));
            chk(c_sel1 == exp_sel(1, w), "R7 write select", 128'(c_sel1), 128'(exp_sel(1, w)));
        end
        do_write(8'h00, 32'h0000_0ABC);
        chk(!c_iw0 && c_sel0 == 0, "R8 port write no flag", 128'({c_iw0, c_sel0}), 128'(0));

        // R3 R4: direction write coinciding with pin change
        fork
            do_write(8'h04, 32'h0000_0F0F);
            begin
                @(negedge pclk);
                pin_w[0] = 32'hCAFE_0E71;
            end
        join
        check_pins("R3 coincident");
        repeat (3) @(negedge pclk);
        apb_xfer(1'b0, 8'h50, 0);
        chk(c_rd0 == 32'h0000_0E71, "R4 coincident pins", 128'(c_rd0), 128'(32'h0E71));
        chk(c_rd1 == 32'hCAFE_0E71, "R4 coincident pins alt", 128'(c_rd1), 128'(32'hCAFE_0E71));

        sweep("final sweep");
        check_pins("R11 final");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule